// File: doc/BRIEF.md
# Latched Interrupt Controller with Masking

This block gathers interrupt requests for a small 8-bit processor core. The requests come from direct external pins, from one group of pins combined into a single source, and from peripheral event pulses. External edges are synchronized, filtered by a selectable polarity and held in a latch. Peripheral events set status flags. A flag stays pending until its enable bit and the core's global mask allow it, or until software clears it.

Pending sources are arbitrated by fixed priority. The winner is registered as a request plus a vector index toward the core's sequencer. The core answers with an acknowledge pulse once it has saved its registers and entered the service routine, and with a return pulse when the routine ends. A wake-up output tells the core that an external interrupt is waiting, so it can leave halt mode.

The register port holds:
- the peripheral enable bits,
- the edge polarity per external source,
- the pin selection of the combined group,
- the status flags, with their two clearing methods.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, irq_req and irq_wake are 0, and reading addresses 0 (enables), 1 (polarity), 2 (group select) and 3 (status) returns 0.
- R2: An external source latches once per qualifying edge of its pin. Polarity bit k (address 1) set to 1 selects rising edges and 0 selects falling edges. irq_wake rises 3 cycles and irq_req 4 cycles after the pin changes. An acknowledge of that source's vector clears the latch.
- R3: Peripheral source j (vector N_EXT+1+j) requests only while status flag j (address 3, bit j) and enable bit j (address 0, bit j) are both set. Otherwise the flag stays set as pending. irq_req rises 2 cycles after the event pulse.
- R4: No request is raised while gmask is 1. A source that is pending while gmask is 1 is requested one cycle after gmask falls.
- R5: When several sources are eligible, the lowest vector index wins. Vectors are direct pins 0..N_EXT-1, the pin group N_EXT, and peripherals after that.
- R6: irq_vec holds its value while irq_req is high. An acknowledge while irq_req is high drops irq_req on the next cycle.
- R7: A write to address 3 clears every flag whose written bit is 0. Flags whose written bit is 1 keep their value.
- R8: A status read that sees flag j set arms a clear. A following read or write of data address 4+j clears flag j. Any other register access in between disarms it. A status read that sees the flag clear arms nothing.
- R9: A flag cleared while pending but not enabled is discarded. Enabling it afterwards raises no request.
- R10: Pin group source N_EXT sees the AND of its pins selected at address 2. While any selected pin is low, its request and wake are suppressed even under rising polarity. Unselected pins have no effect.
- R11: irq_wake is high whenever an external latch is pending and not suppressed, regardless of gmask.
- R12: After an acknowledge, no new request is raised until irq_iret pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | N_EXT | Direct external interrupt pins |
| grp_pin | input | GRP_W | Pins combined into one external source |
| periph_evt | input | N_PER | Peripheral event pulses that set status flags |
| gmask | input | 1 | Core global interrupt mask |
| irq_ack | input | 1 | Core entered the service routine |
| irq_iret | input | 1 | Core returned from the service routine |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the access |
| irq_req | output | 1 | Request to the core to stack and vector |
| irq_vec | output | VEC_W | Vector index of the requested source |
| irq_wake | output | 1 | External interrupt pending, leave halt |

## Verification
The bench attacks the cases where a pending request must survive or must vanish:
- A flag raised under the mask or with its enable off must be taken later, not dropped. A design that lost it would never request.
- A flag cleared before being enabled must never fire. A design without a real pending latch would fire once the enable is written.
- The two-step clear is probed with an access in between, and with a status read that saw the flag low. A design that armed too freely would clear flags software never saw.
- On the pin group, a low selected pin must hide a latched edge under rising polarity. A plain edge detector would request anyway.
- A held level must latch only once. An edge detector that compared the wrong samples would request again after the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DEF_N_EXT = 2;
    localparam int DEF_GRP_W = 3;
    localparam int DEF_N_PER = 3;
    localparam int REG_AW    = 3;
    localparam int REG_DW    = 8;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL  = 3'd0,
        RA_POL   = 3'd1,
        RA_GSEL  = 3'd2,
        RA_STAT  = 3'd3,
        RA_DATA0 = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] wdata;
    } reg_acc_t;

    function automatic logic [REG_AW-1:0] data_addr(input int idx);
        return REG_AW'(int'(RA_DATA0) + idx);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic rise_sel,
    input  logic gate,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic held_q;
    logic hit;

    // compare current synchronized sample against the previous one
    always_comb hit = rise_sel ? (lvl & ~prev_q) : (~lvl & prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            if (hit)      held_q <= 1'b1;
            else if (clr) held_q <= 1'b0;
        end
    end

    assign pend = held_q & gate;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int N_XSRC = DEF_N_EXT + 1,
    parameter int GRP_W  = DEF_GRP_W,
    parameter int N_PER  = DEF_N_PER
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_acc_t          acc,
    input  logic [N_PER-1:0]  evt,
    output logic [REG_DW-1:0] rdata,
    output logic [N_PER-1:0]  en_q,
    output logic [N_XSRC-1:0] pol_q,
    output logic [GRP_W-1:0]  gsel_q,
    output logic [N_PER-1:0]  flag_q
);
    logic [N_PER-1:0] armed_q;
    logic [N_PER-1:0] seq_clr;
    logic [N_PER-1:0] flag_d;
    logic             stat_rd;
    logic             stat_wr;
    logic             unused_wdata;

    assign unused_wdata = ^acc.wdata;

    always_comb begin
        stat_rd = acc.en && !acc.we && (acc.addr == RA_STAT);
        stat_wr = acc.en &&  acc.we && (acc.addr == RA_STAT);
        for (int j = 0; j < N_PER; j++) begin
            seq_clr[j] = acc.en && (acc.addr == data_addr(j)) && armed_q[j];
        end
        flag_d = flag_q;
        if (stat_wr) flag_d = flag_q & acc.wdata[N_PER-1:0];
        // a new event in the same cycle wins over any clear
        flag_d = (flag_d & ~seq_clr) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            pol_q   <= '0;
            gsel_q  <= '0;
            flag_q  <= '0;
            armed_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (acc.en) armed_q <= stat_rd ? flag_q : '0;
            if (acc.en && acc.we) begin
                case (acc.addr)
                    RA_CTRL: en_q   <= acc.wdata[N_PER-1:0];
                    RA_POL:  pol_q  <= acc.wdata[N_XSRC-1:0];
                    RA_GSEL: gsel_q <= acc.wdata[GRP_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (acc.addr)
            RA_CTRL: rdata = REG_DW'(en_q);
            RA_POL:  rdata = REG_DW'(pol_q);
            RA_GSEL: rdata = REG_DW'(gsel_q);
            RA_STAT: rdata = REG_DW'(flag_q);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N_SRC = 6,
    parameter int VEC_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] elig,
    input  logic             gmask,
    input  logic             ack,
    input  logic             iret,
    output logic             req,
    output logic [VEC_W-1:0] vec,
    output logic             in_svc
);
    localparam int PAD = 1 << VEC_W;

    logic [PAD-1:0]   elig_pad;
    logic             win_hit;
    logic [VEC_W-1:0] win_idx;
    logic             busy_q;
    logic             svc_q;
    logic [VEC_W-1:0] vec_q;
    logic             held_ok;

    assign elig_pad = PAD'(elig);

    always_comb begin
        win_hit = 1'b0;
        win_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_hit = 1'b1;
                win_idx = VEC_W'(i);
            end
        end
    end

    assign held_ok = elig_pad[vec_q];
    assign req     = busy_q & held_ok;
    assign vec     = vec_q;
    assign in_svc  = svc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            svc_q  <= 1'b0;
            vec_q  <= '0;
        end else begin
            if (iret) svc_q <= 1'b0;
            if (ack && req) begin
                svc_q  <= 1'b1;
                busy_q <= 1'b0;
            end else if (busy_q && !held_ok) begin
                busy_q <= 1'b0;
            end else if (!busy_q && win_hit && !gmask && !svc_q) begin
                busy_q <= 1'b1;
                vec_q  <= win_idx;
            end
        end
    end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_pkg::*;
#(
    parameter int  N_EXT = DEF_N_EXT,
    parameter int  GRP_W = DEF_GRP_W,
    parameter int  N_PER = DEF_N_PER,
    localparam int VEC_W = $clog2(N_EXT + 1 + N_PER)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic [GRP_W-1:0]  grp_pin,
    input  logic [N_PER-1:0]  periph_evt,
    input  logic              gmask,
    input  logic              irq_ack,
    input  logic              irq_iret,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              irq_wake
);
    localparam int N_XSRC = N_EXT + 1;
    localparam int N_SRC  = N_XSRC + N_PER;

    reg_acc_t          acc;
    logic [N_EXT-1:0]  d_sync;
    logic [GRP_W-1:0]  g_sync;
    logic [N_PER-1:0]  en_q;
    logic [N_XSRC-1:0] pol_q;
    logic [GRP_W-1:0]  gsel_q;
    logic [N_PER-1:0]  flag_q;
    logic              grp_ok;
    logic [N_XSRC-1:0] ext_lvl;
    logic [N_XSRC-1:0] ext_gate;
    logic [N_XSRC-1:0] ext_pend;
    logic [N_SRC-1:0]  elig;
    logic              in_svc;

    assign acc = '{en: reg_en, we: reg_we, addr: reg_addr, wdata: reg_wdata};

    irq_sync #(.W(N_EXT)) u_sync_d (.clk(clk), .rst(rst), .d(ext_pin), .q(d_sync));
    irq_sync #(.W(GRP_W)) u_sync_g (.clk(clk), .rst(rst), .d(grp_pin), .q(g_sync));

    irq_regs #(.N_XSRC(N_XSRC), .GRP_W(GRP_W), .N_PER(N_PER)) u_regs (
        .clk(clk), .rst(rst), .acc(acc), .evt(periph_evt), .rdata(reg_rdata),
        .en_q(en_q), .pol_q(pol_q), .gsel_q(gsel_q), .flag_q(flag_q)
    );

    // group level is high only when every selected pin is high
    assign grp_ok   = &(g_sync | ~gsel_q);
    assign ext_lvl  = {grp_ok, d_sync};
    assign ext_gate = {grp_ok, {N_EXT{1'b1}}};

    for (genvar k = 0; k < N_XSRC; k++) begin : g_ext
        logic ack_clr;
        assign ack_clr = irq_ack && irq_req && (irq_vec == VEC_W'(k));
        irq_edge_latch u_lat (
            .clk(clk), .rst(rst), .lvl(ext_lvl[k]), .rise_sel(pol_q[k]),
            .gate(ext_gate[k]), .clr(ack_clr), .pend(ext_pend[k])
        );
    end

    assign elig     = {flag_q & en_q, ext_pend};
    assign irq_wake = |ext_pend;

    irq_arbiter #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
        .clk(clk), .rst(rst), .elig(elig), .gmask(gmask), .ack(irq_ack),
        .iret(irq_iret), .req(irq_req), .vec(irq_vec), .in_svc(in_svc)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int N_XSRC = 3,
    parameter int N_SRC  = 6,
    parameter int VEC_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_ack,
    input logic             gmask,
    input logic             irq_wake,
    input logic             in_svc
);
    p_no_raise_masked_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> !$past(gmask));

    p_vec_range_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec < VEC_W'(N_SRC)));

    p_vec_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack) |=> (!irq_req || $stable(irq_vec)));

    p_ack_drops_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> !irq_req);

    p_ext_wakes_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_req && (irq_vec < VEC_W'(N_XSRC))) |-> irq_wake);

    p_no_nest_r12: assert property (@(posedge clk) disable iff (rst)
        in_svc |-> !irq_req);
endmodule

bind irq_ctrl_top irq_ctrl_chk #(
    .N_XSRC(N_EXT + 1), .N_SRC(N_EXT + 1 + N_PER), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .gmask(gmask), .irq_wake(irq_wake), .in_svc(in_svc)
);

// File: tb/irq_ctrl_top_tb_top.sv
module irq_ctrl_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ext_pin = 2'b11;
    logic [2:0] grp_pin = 3'b111;
    logic [2:0] periph_evt = '0;
    logic       gmask = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_iret = 1'b0;
    logic       reg_en = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [2:0] irq_vec;
    logic       irq_wake;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [2:0] A_EN = 3'd0, A_POL = 3'd1, A_GSEL = 3'd2, A_STAT = 3'd3;
    localparam logic [2:0] A_D0 = 3'd4, A_D1 = 3'd5, A_D2 = 3'd6;

    // {evt[2:0], en[2:0], exp_req, exp_vec[2:0]}
    localparam logic [9:0] TAB [8] = '{
        {3'b001, 3'b111, 1'b1, 3'd3},
        {3'b110, 3'b111, 1'b1, 3'd4},
        {3'b111, 3'b111, 1'b1, 3'd3},
        {3'b111, 3'b110, 1'b1, 3'd4},
        {3'b100, 3'b100, 1'b1, 3'd5},
        {3'b011, 3'b100, 1'b0, 3'd0},
        {3'b101, 3'b001, 1'b1, 3'd3},
        {3'b000, 3'b111, 1'b0, 3'd0}
    };

    irq_ctrl_top dut_i (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .grp_pin(grp_pin),
        .periph_evt(periph_evt), .gmask(gmask), .irq_ack(irq_ack),
        .irq_iret(irq_iret), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_wake(irq_wake)
    );

    always #10 clk = ~clk;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(1);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        cyc(1);
        reg_en = 1'b0;
    endtask

    task automatic pulse_evt(input logic [2:0] m);
        periph_evt = m;
        cyc(1);
        periph_evt = '0;
    endtask

    task automatic do_ack;
        irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    endtask

    task automatic do_iret;
        irq_iret = 1'b1; cyc(1); irq_iret = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [9:0] e;
        cyc(3);
        rst = 1'b0;
        cyc(4);

        // R1 reset state
        check("R1 req", int'(irq_req), 0);
        check("R1 wake", int'(irq_wake), 0);
        reg_rd(A_EN, d);   check("R1 enables", int'(d), 0);
        reg_rd(A_POL, d);  check("R1 polarity", int'(d), 0);
        reg_rd(A_GSEL, d); check("R1 group select", int'(d), 0);
        reg_rd(A_STAT, d); check("R1 status", int'(d), 0);

        // R3/R5 vector table: peripheral priority and enables
        for (int i = 0; i < 8; i++) begin
            e = TAB[i];
            reg_wr(A_EN, {5'b0, e[6:4]});
            pulse_evt(e[9:7]);
            cyc(1);
            check("R3 R5 table req", int'(irq_req), int'(e[3]));
            if (e[3]) check("R5 table vec", int'(irq_vec), int'(e[2:0]));
            reg_wr(A_STAT, 8'h00);
            cyc(1);
            check("R7 table cleared", int'(irq_req), 0);
            reg_wr(A_EN, 8'h00);
        end

        // R4 masked, R3 pending until enabled
        gmask = 1'b1;
        reg_wr(A_EN, 8'h01);
        pulse_evt(3'b001);
        cyc(3);
        check("R4 no req under mask", int'(irq_req), 0);
        reg_rd(A_STAT, d); check("R3 pending flag", int'(d), 1);
        reg_wr(A_EN, 8'h00);
        gmask = 1'b0;
        cyc(3);
        check("R3 disabled no req", int'(irq_req), 0);
        reg_wr(A_EN, 8'h01);
        cyc(1);
        check("R3 pending taken req", int'(irq_req), 1);
        check("R3 pending taken vec", int'(irq_vec), 3);

        // R6 ack, R12 no nesting until iret
        do_ack();
        check("R6 ack drops req", int'(irq_req), 0);
        cyc(4);
        check("R12 no req in service", int'(irq_req), 0);
        do_iret();
        cyc(1);
        check("R12 req after iret", int'(irq_req), 1);
        check("R12 vec after iret", int'(irq_vec), 3);
        reg_wr(A_STAT, 8'h00);
        check("R7 clear withdraws req", int'(irq_req), 0);
        reg_wr(A_EN, 8'h00);
        cyc(1);

        // R7 write-one keeps flag
        pulse_evt(3'b011);
        reg_wr(A_STAT, 8'h06);
        reg_rd(A_STAT, d); check("R7 write zero clears", int'(d), 2);
        reg_wr(A_STAT, 8'h00);

        // R9 discard of pending not enabled
        pulse_evt(3'b010);
        reg_wr(A_STAT, 8'h00);
        reg_wr(A_EN, 8'h07);
        cyc(3);
        check("R9 discarded no req", int'(irq_req), 0);
        reg_rd(A_STAT, d); check("R9 flag gone", int'(d), 0);
        reg_wr(A_EN, 8'h00);

        // R8 read-then-access clear sequence
        pulse_evt(3'b011);
        reg_rd(A_STAT, d); check("R8 flags seen", int'(d), 3);
        reg_rd(A_D1, d);
        reg_rd(A_STAT, d); check("R8 seq clears flag1", int'(d), 1);
        reg_wr(A_POL, 8'h00);
        reg_wr(A_D0, 8'h00);
        reg_rd(A_STAT, d); check("R8 disarmed by other access", int'(d), 1);
        reg_wr(A_D0, 8'h00);
        reg_rd(A_STAT, d); check("R8 seq write clears flag0", int'(d), 0);
        pulse_evt(3'b100);
        reg_rd(A_D2, d);
        reg_rd(A_STAT, d); check("R8 unarmed read keeps flag2", int'(d), 4);
        reg_wr(A_STAT, 8'h00);

        // R2 falling edge on pin 0
        ext_pin[0] = 1'b0;
        cyc(3);
        check("R11 wake after latch", int'(irq_wake), 1);
        check("R2 req not yet", int'(irq_req), 0);
        cyc(1);
        check("R2 falling req", int'(irq_req), 1);
        check("R2 falling vec", int'(irq_vec), 0);
        cyc(3);
        do_ack();
        check("R2 ack clears req", int'(irq_req), 0);
        check("R2 ack clears latch", int'(irq_wake), 0);
        do_iret();
        cyc(4);
        check("R2 held level latches once", int'(irq_wake), 0);
        ext_pin[0] = 1'b1;
        cyc(5);
        check("R2 rising ignored on falling source", int'(irq_wake), 0);

        // R2 rising on pin 1, R11 wake under mask, R5 priority
        reg_wr(A_POL, 8'h02);
        ext_pin[1] = 1'b0;
        cyc(5);
        check("R2 falling ignored on rising source", int'(irq_wake), 0);
        gmask = 1'b1;
        ext_pin[1] = 1'b1;
        cyc(4);
        check("R11 wake under mask", int'(irq_wake), 1);
        check("R4 masked ext no req", int'(irq_req), 0);
        ext_pin[0] = 1'b0;
        cyc(4);
        check("R4 still masked", int'(irq_req), 0);
        gmask = 1'b0;
        cyc(1);
        check("R4 req after unmask", int'(irq_req), 1);
        check("R5 lowest ext wins", int'(irq_vec), 0);
        do_ack();
        do_iret();
        cyc(1);
        check("R5 next source req", int'(irq_req), 1);
        check("R5 next source vec", int'(irq_vec), 1);
        do_ack();
        do_iret();
        ext_pin[0] = 1'b1;
        cyc(4);
        check("R2 all latches served", int'(irq_wake), 0);

        // R10 pin group, falling polarity
        reg_wr(A_GSEL, 8'h03);
        grp_pin[0] = 1'b0;
        cyc(5);
        check("R10 low pin hides wake", int'(irq_wake), 0);
        check("R10 low pin hides req", int'(irq_req), 0);
        grp_pin[0] = 1'b1;
        cyc(2);
        check("R10 wake after release", int'(irq_wake), 1);
        cyc(1);
        check("R10 req after release", int'(irq_req), 1);
        check("R10 group vec", int'(irq_vec), 2);
        do_ack();
        do_iret();
        cyc(2);

        // R10 pin group, rising polarity
        reg_wr(A_POL, 8'h06);
        grp_pin[1] = 1'b0;
        cyc(5);
        check("R10 falling ignored rising group", int'(irq_wake), 0);
        grp_pin[1] = 1'b1;
        cyc(3);
        check("R10 rising group wake", int'(irq_wake), 1);
        cyc(1);
        check("R10 rising group req", int'(irq_req), 1);
        grp_pin[0] = 1'b0;
        cyc(2);
        check("R10 low pin masks rising req", int'(irq_req), 0);
        check("R10 low pin masks rising wake", int'(irq_wake), 0);
        grp_pin[0] = 1'b1;
        cyc(3);
        check("R10 req restored", int'(irq_req), 1);
        check("R10 vec restored", int'(irq_vec), 2);
        do_ack();
        do_iret();
        grp_pin[2] = 1'b0;
        cyc(5);
        check("R10 unselected pin no effect", int'(irq_wake), 0);
        grp_pin[2] = 1'b1;
        cyc(2);

        summary();
        $finish;
    end
endmodule